// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block counts system clocks from the last software restart. When the selected period completes, it raises an interrupt flag. That flag is a first warning that software has failed to service the timer. The completion also opens a fixed grace window of 512 clocks. If software does not restart the timer before that window closes, the block raises a reset flag. When resets are enabled, it also drives a reset request towards the chip's reset logic.

The period is always a power of two. Its exponent is a base value plus three times the two-bit timeout select. The base value comes from a two-bit clock-mode field and a clock-multiplier mode bit. Both flags are sticky. Each flag is cleared by its own strobe, and a global reset clears both. A parameter lowers every exponent by a fixed amount, so that short periods can be used for checking. At its default value of zero, the periods are the full-length ones.

Top module: `wdog_two_stage`

## Requirements
- R1: While reset is active, and immediately after it, `irq_flag`, `rst_flag` and `rst_req` are 0. Asserting reset while the flags are set clears them.
- R2: The period is L = 2^e clocks, where e = base + 3*`tmo_sel` - `EXP_SHIFT`. The base is 15 for `clk_mode`=00 with `mult_mode`=1, 16 for `clk_mode`=00 with `mult_mode`=0, 17 for `clk_mode`=01 or 10, and 25 for `clk_mode`=11 (where `mult_mode` has no effect). At the default `clk_mode`=10, the four selects give 2^17, 2^20, 2^23 and 2^26.
- R3: `irq_flag` is 0 up to L-1 clocks after the clock edge that samples `restart`=1, and is 1 exactly L clocks after that edge.
- R4: Exactly 512 clocks after the edge that sets `irq_flag`, `rst_flag` becomes 1. This happens whether or not software clears `irq_flag` in between. During the window it is 0.
- R5: `rst_req` is 1 only while `rst_flag` is 1 and `rst_enable` is 1. With `rst_enable`=0 the request is suppressed, though the flag is still set.
- R6: A `restart` strobe zeroes the counter and cancels any grace window in progress, so no reset flag follows from that window. A restart sampled on the same edge that would complete the period wins: no interrupt is raised, and a full new period begins.
- R7: `irq_flag` and `rst_flag` hold until `clr_irq` or `clr_rst` respectively is sampled. If a flag's set event and its clear strobe fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the unit of every period |
| rst_n | input | 1 | Asynchronous active-low global reset |
| tmo_sel | input | 2 | Timeout select, adds 3*value to the exponent |
| clk_mode | input | 2 | Clock-mode field choosing the base exponent |
| mult_mode | input | 1 | Clock-multiplier mode bit, used when clk_mode is 00 |
| rst_enable | input | 1 | Allows the reset request when 1 |
| restart | input | 1 | Software restart strobe |
| clr_irq | input | 1 | Clears the interrupt flag |
| clr_rst | input | 1 | Clears the reset flag |
| irq_flag | output | 1 | Sticky first-stage warning |
| rst_flag | output | 1 | Sticky flag marking an expired grace window |
| rst_req | output | 1 | Reset request, reset flag gated by rst_enable |

## Verification
Two pairs of events can land on the same edge. The first pair is a software restart and the completion of the period. The bench raises `restart` on exactly the edge where the period would end. It then expects the interrupt flag to stay low and to rise only one full period later. The second pair is a flag's set event and its clear strobe. The bench holds `clr_irq` across the completing edge and `clr_rst` across the window's last edge, and expects each flag to read 1 afterwards. Around these cases the bench sweeps every select and clock mode of a shortened configuration, the mode 11 periods being limited to the two shortest selects. It times each edge against 2^e and 512 computed arithmetically.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int EXP_STEP = 3;
    localparam int SEL_MAX  = 3;
    localparam int MAX_BASE = 25;

    function automatic int base_exp(input logic [1:0] mode, input logic mult);
        case (mode)
            2'b00:   return mult ? 15 : 16;
            2'b11:   return 25;
            default: return 17;
        endcase
    endfunction
endpackage

// File: rtl/wdt_term.sv
`timescale 1ns/1ps
module wdt_term #(
    parameter int EXP_SHIFT = 0,
    parameter int CNT_W     = 34
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       tmo_sel,
    input  logic [1:0]       clk_mode,
    input  logic             mult_mode,
    output logic             hit
);
    int               e;
    logic [CNT_W-1:0] last_val;

    always_comb begin
        e = wdt_pkg::base_exp(clk_mode, mult_mode)
            + wdt_pkg::EXP_STEP * int'(tmo_sel) - EXP_SHIFT;
        if (e < 1)     e = 1;
        if (e > CNT_W) e = CNT_W;
        last_val = {CNT_W{1'b1}} >> (CNT_W - e);
        // >= keeps a lowered select from skipping past the terminal value
        hit = (cnt >= last_val);
    end
endmodule

// File: rtl/wdt_grace.sv
`timescale 1ns/1ps
module wdt_grace #(
    parameter int GRACE = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic active,
    output logic expire
);
    localparam int            GW   = (GRACE > 1) ? $clog2(GRACE) : 1;
    localparam logic [GW-1:0] LAST = GW'(GRACE - 1);

    typedef struct packed {
        logic          act;
        logic [GW-1:0] cnt;
    } grace_t;

    grace_t s_d, s_q;

    assign active = s_q.act;
    assign expire = s_q.act && (s_q.cnt == LAST);

    always_comb begin
        s_d = s_q;
        if (cancel) begin
            s_d.act = 1'b0;
            s_d.cnt = '0;
        end else if (start) begin
            s_d.act = 1'b1;
            s_d.cnt = '0;
        end else if (s_q.act) begin
            if (expire) begin
                s_d.act = 1'b0;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: an open window advances by one each clock until it closes
    p_grace_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.act && !cancel && !start && !expire) |=>
        (s_q.act && s_q.cnt == $past(s_q.cnt) + 1'b1));

    // R6: a cancel always closes the window
    p_cancel_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !s_q.act);
endmodule

// File: rtl/wdog_two_stage.sv
`timescale 1ns/1ps
module wdog_two_stage #(
    parameter int EXP_SHIFT = 0,
    parameter int GRACE     = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] tmo_sel,
    input  logic [1:0] clk_mode,
    input  logic       mult_mode,
    input  logic       rst_enable,
    input  logic       restart,
    input  logic       clr_irq,
    input  logic       clr_rst,
    output logic       irq_flag,
    output logic       rst_flag,
    output logic       rst_req
);
    localparam int MAX_EXP = wdt_pkg::MAX_BASE
                           + wdt_pkg::EXP_STEP * wdt_pkg::SEL_MAX - EXP_SHIFT;
    localparam int CNT_W   = (MAX_EXP > 1) ? MAX_EXP : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             rstf;
    } wd_state_t;

    wd_state_t s_d, s_q;

    logic hit_raw, term_hit, grace_start, grace_active, grace_expire;

    wdt_term #(.EXP_SHIFT(EXP_SHIFT), .CNT_W(CNT_W)) u_term (
        .cnt       (s_q.cnt),
        .tmo_sel   (tmo_sel),
        .clk_mode  (clk_mode),
        .mult_mode (mult_mode),
        .hit       (hit_raw)
    );

    wdt_grace #(.GRACE(GRACE)) u_grace (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (grace_start),
        .cancel (restart),
        .active (grace_active),
        .expire (grace_expire)
    );

    assign term_hit    = hit_raw && !grace_active;
    assign grace_start = term_hit && !restart;

    always_comb begin
        s_d = s_q;
        if (restart || term_hit || grace_active) s_d.cnt = '0;
        else                                     s_d.cnt = s_q.cnt + 1'b1;
        s_d.irq  = grace_start | (s_q.irq & ~clr_irq);
        s_d.rstf = (grace_expire & ~restart) | (s_q.rstf & ~clr_rst);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_flag = s_q.irq;
    assign rst_flag = s_q.rstf;
    assign rst_req  = s_q.rstf & rst_enable;

    // R6: a restart leaves a zeroed counter and no open window
    p_restart_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (s_q.cnt == '0 && !grace_active));

    // R3: a completed period raises the flag and opens the window
    p_timeout_raises_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (term_hit && !restart) |=> (s_q.irq && grace_active));

    // R4: the reset flag only rises out of an open window
    p_rstf_after_grace_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.rstf) |-> $past(grace_active));

    // R7: flags hold without their clear strobe
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.irq && !clr_irq) |=> s_q.irq);

    p_rstf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rstf && !clr_rst) |=> s_q.rstf);
endmodule

// File: tb/tb_wdog_two_stage.sv
`timescale 1ns/1ps
module tb_wdog_two_stage;
    localparam int SH = 13;
    localparam int GR = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] tmo_sel = '0, clk_mode = '0;
    logic mult_mode = 1'b0, rst_enable = 1'b0, restart = 1'b0;
    logic clr_irq = 1'b0, clr_rst = 1'b0;
    logic irq_flag, rst_flag, rst_req;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    wdog_two_stage #(.EXP_SHIFT(SH), .GRACE(GR)) dut (
        .clk(clk), .rst_n(rst_n), .tmo_sel(tmo_sel), .clk_mode(clk_mode),
        .mult_mode(mult_mode), .rst_enable(rst_enable), .restart(restart),
        .clr_irq(clr_irq), .clr_rst(clr_rst),
        .irq_flag(irq_flag), .rst_flag(rst_flag), .rst_req(rst_req)
    );

    function automatic int exp_of(int cm, int mu, int ts);
        int b;
        if (cm == 0)      b = (mu != 0) ? 15 : 16;
        else if (cm == 3) b = 25;
        else              b = 17;
        return b + 3 * ts - SH;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        tick(1);
        restart = 1'b0;
    endtask

    task automatic clear_all();
        clr_irq = 1'b1;
        clr_rst = 1'b1;
        tick(1);
        clr_irq = 1'b0;
        clr_rst = 1'b0;
    endtask

    task automatic set_cfg(int cm, int mu, int ts, bit en);
        clk_mode   = 2'(cm);
        mult_mode  = (mu != 0);
        tmo_sel    = 2'(ts);
        rst_enable = en;
    endtask

    task automatic run_case(int cm, int mu, int ts, bit en);
        int len;
        len = 1 << exp_of(cm, mu, ts);
        set_cfg(cm, mu, ts, en);
        pulse_restart();
        tick(len - 1);
        check($sformatf("R3 irq early cm%0d mu%0d ts%0d", cm, mu, ts), irq_flag, 0);
        tick(1);
        check($sformatf("R2 R3 irq at 2^e cm%0d mu%0d ts%0d", cm, mu, ts), irq_flag, 1);
        check("R4 rst flag at window start", rst_flag, 0);
        tick(GR - 1);
        check("R4 rst flag before 512", rst_flag, 0);
        check("R7 irq held in window", irq_flag, 1);
        tick(1);
        check($sformatf("R4 rst flag at 512 cm%0d mu%0d ts%0d", cm, mu, ts), rst_flag, 1);
        check("R5 request follows enable", rst_req, en);
        clear_all();
        check("R7 flags cleared", {irq_flag, rst_flag}, 0);
    endtask

    initial begin
        tick(3);
        check("R1 irq in reset", irq_flag, 0);
        check("R1 rst flag in reset", rst_flag, 0);
        check("R1 request in reset", rst_req, 0);
        rst_n = 1'b1;
        check("R1 flags after release", {irq_flag, rst_flag, rst_req}, 0);

        for (int cm = 0; cm < 3; cm++)
            for (int mu = 0; mu < 2; mu++)
                for (int ts = 0; ts < 4; ts++)
                    run_case(cm, mu, ts, bit'(ts % 2));
        run_case(3, 1, 0, 1'b1);
        run_case(3, 1, 1, 1'b0);
        run_case(3, 0, 0, 1'b1);

        // R5: flag set with enable low, then enable raised
        set_cfg(0, 1, 0, 1'b0);
        pulse_restart();
        tick(4 + GR);
        check("R5 flag set while disabled", rst_flag, 1);
        check("R5 request suppressed", rst_req, 0);
        rst_enable = 1'b1;
        #1;
        check("R5 request once enabled", rst_req, 1);
        rst_enable = 1'b0;
        clear_all();

        // R6: restart in the middle of a window cancels it
        pulse_restart();
        tick(4);
        check("R6 irq before cancel", irq_flag, 1);
        tick(300);
        pulse_restart();
        tick(300);
        check("R6 old window cancelled", rst_flag, 0);
        tick(215);
        check("R6 new window not yet over", rst_flag, 0);
        tick(1);
        check("R6 new window expires", rst_flag, 1);
        clear_all();

        // R6: restart on the completing edge wins
        pulse_restart();
        tick(3);
        restart = 1'b1;
        tick(1);
        restart = 1'b0;
        check("R6 restart beats completion", irq_flag, 0);
        tick(3);
        check("R6 full new period", irq_flag, 0);
        tick(1);
        check("R6 irq after new period", irq_flag, 1);

        // R4/R7: software clears irq mid window, reset still follows
        clr_irq = 1'b1;
        tick(1);
        clr_irq = 1'b0;
        check("R7 irq clear strobe", irq_flag, 0);
        tick(GR - 2);
        clr_rst = 1'b1;
        tick(1);
        clr_rst = 1'b0;
        check("R7 set beats clear on rst flag", rst_flag, 1);
        check("R4 irq stays cleared", irq_flag, 0);
        clear_all();

        // R7: clear strobe on the irq setting edge
        pulse_restart();
        tick(3);
        clr_irq = 1'b1;
        tick(1);
        clr_irq = 1'b0;
        check("R7 set beats clear on irq", irq_flag, 1);
        tick(GR);
        check("R4 flag before mid reset", rst_flag, 1);

        // R1: reset clears set flags
        rst_n = 1'b0;
        tick(1);
        check("R1 mid reset clears", {irq_flag, rst_flag, rst_req}, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule